// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a stream of single-cycle input events by a programmable ratio N = P·B + A and emits one single-cycle pulse for every N events. It models the counting side of a dual-modulus prescaler. In each output period, a swallow count A selects how many prescaler cycles run at the larger modulus P+1. The remaining B−A prescaler cycles run at P. A main count B sets the total number of prescaler cycles per period.

The settings (prescaler pair, A and B) are presented on input buses and take effect only when a load strobe is asserted. A legal load is held as a pending setting and becomes active at the boundary between two output periods, so a running period always finishes with the ratio it started with. An illegal load is rejected: an error flag rises and the last accepted setting stays in force.

Top module: `dmp_divider`

## Requirements
- R1: After reset the active setting is prescaler code 00, A=0, B=3 (N=24). `div_o` and `cfg_err_o` are low, and the first pulse follows the 24th event.
- R2: The 2-bit prescaler code selects P as follows: 00 gives 8, 01 gives 16, 10 gives 32, 11 gives 64. Each output period contains exactly P·B+A events.
- R3: `div_o` is high for exactly one clock cycle per period. It goes high in the cycle after the clock edge at which the completing event was sampled.
- R4: Only cycles with `evt_i` high are counted. Idle cycles of any length leave the count unchanged.
- R5: A load with B below 3 sets `cfg_err_o` in the next cycle, and the previous setting stays in force.
- R6: A load with B less than A sets `cfg_err_o` in the next cycle, and the previous setting stays in force.
- R7: A legal load (B at least 3 and B at least A) clears `cfg_err_o` in the next cycle.
- R8: A legal load made in the middle of a period leaves that period at its old length. The new ratio governs the next full period.
- R9: A legal load sampled at the same edge as a period's completing event governs the very next period.
- R10: While `load_i` is low, the values on `mode_i`, `a_i` and `b_i` have no effect on the divider.
- R11: The boundary settings A=0 and A=B=63 each give periods of P·B+A events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 1 | Input event strobe, one event per high cycle |
| load_i | input | 1 | Commit strobe for the setting buses |
| mode_i | input | 2 | Prescaler pair code |
| a_i | input | 6 | Swallow count A |
| b_i | input | 13 | Main count B |
| div_o | output | 1 | Divided output pulse |
| cfg_err_o | output | 1 | Last load was rejected |

## Verification
The two functions that can meet in one cycle are the commit of a new setting and the completion of an output period. The bench provokes this by tracking its own event count and asserting `load_i` in the same cycle as the final event of a period. It then judges the result by whether the following period has the new length (R9), rather than finishing one more period at the old length. A rejected load and a period end are also made to coincide, to show that the old ratio carries on.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
    localparam int MODE_W = 2;
    localparam int A_W    = 6;
    localparam int B_W    = 13;
    localparam int PC_W   = 7;   // prescaler count, holds up to 64
    localparam int B_MIN  = 3;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [A_W-1:0]    a;
        logic [B_W-1:0]    b;
    } dmp_cfg_t;

    // Base modulus P for a prescaler code
    function automatic logic [PC_W-1:0] base_mod(input logic [MODE_W-1:0] m);
        logic [PC_W-1:0] p;
        case (m)
            2'b00:   p = PC_W'(8);
            2'b01:   p = PC_W'(16);
            2'b10:   p = PC_W'(32);
            default: p = PC_W'(64);
        endcase
        return p;
    endfunction
endpackage

// File: rtl/dmp_prescaler.sv
module dmp_prescaler
    import dmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              plus_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [PC_W-1:0] cnt;
    } pre_st_t;

    pre_st_t s_d, s_q;
    logic [PC_W-1:0] last;
    logic tick;

    always_comb begin
        s_d  = s_q;
        last = base_mod(mode_i) - PC_W'(1) + PC_W'(plus_i);
        tick = evt_i && (s_q.cnt == last);
        if (tick)       s_d.cnt = '0;
        else if (evt_i) s_d.cnt = s_q.cnt + PC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = tick;

    // R2: the prescaler count never passes the active modulus
    a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= last);
endmodule

// File: rtl/dmp_cycle_ctr.sv
module dmp_cycle_ctr
    import dmp_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output logic           plus_o,
    output logic           end_o
);
    typedef struct packed {
        logic [B_W-1:0] k;
    } cyc_st_t;

    cyc_st_t s_d, s_q;
    logic fin;

    always_comb begin
        s_d    = s_q;
        plus_o = s_q.k < {{(B_W-A_W){1'b0}}, a_i};
        fin    = tick_i && (s_q.k == b_i - B_W'(1));
        if (fin)         s_d.k = '0;
        else if (tick_i) s_d.k = s_q.k + B_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign end_o = fin;

    // R2: the prescaler-cycle index stays below B
    a_r2_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.k < b_i);
endmodule

// File: rtl/dmp_cfg.sv
module dmp_cfg
    import dmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  dmp_cfg_t cfg_i,
    input  logic     end_i,
    output dmp_cfg_t act_o,
    output logic     err_o
);
    typedef struct packed {
        dmp_cfg_t act;
        dmp_cfg_t pend;
        logic     pend_v;
        logic     err;
    } cfg_st_t;

    localparam dmp_cfg_t CFG_RST = '{mode: '0, a: '0, b: B_W'(B_MIN)};

    cfg_st_t s_d, s_q;
    logic legal;

    always_comb begin
        s_d   = s_q;
        legal = (cfg_i.b >= B_W'(B_MIN)) && (cfg_i.b >= {{(B_W-A_W){1'b0}}, cfg_i.a});
        if (load_i) begin
            if (legal) begin
                s_d.pend   = cfg_i;
                s_d.pend_v = 1'b1;
                s_d.err    = 1'b0;
            end else begin
                s_d.err    = 1'b1;
            end
        end
        if (end_i && s_d.pend_v) begin
            s_d.act    = s_d.pend;
            s_d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{act: CFG_RST, pend: CFG_RST, pend_v: 1'b0, err: 1'b0};
        else        s_q <= s_d;
    end

    assign act_o = s_q.act;
    assign err_o = s_q.err;

    // R5 / R6: a rejected load raises the flag
    a_r5_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !legal) |=> err_o);
    // R7: an accepted load clears the flag
    a_r7_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && legal) |=> !err_o);
    // R10, R8: the active setting only moves at a period boundary
    a_r10_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
        !end_i |=> $stable(act_o));
    // R6: the active setting is always a legal one
    a_r6_active_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o.b >= B_W'(B_MIN)) && (act_o.b >= {{(B_W-A_W){1'b0}}, act_o.a}));
endmodule

// File: rtl/dmp_divider.sv
module dmp_divider
    import dmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              load_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [A_W-1:0]    a_i,
    input  logic [B_W-1:0]    b_i,
    output logic              div_o,
    output logic              cfg_err_o
);
    typedef struct packed {
        logic div;
    } top_st_t;

    top_st_t  s_d, s_q;
    dmp_cfg_t act, req;
    logic     tick, plus, fin;

    assign req = '{mode: mode_i, a: a_i, b: b_i};

    dmp_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .cfg_i  (req),
        .end_i  (fin),
        .act_o  (act),
        .err_o  (cfg_err_o)
    );

    dmp_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .plus_i (plus),
        .mode_i (act.mode),
        .tick_o (tick)
    );

    dmp_cycle_ctr u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .a_i    (act.a),
        .b_i    (act.b),
        .plus_o (plus),
        .end_o  (fin)
    );

    always_comb begin
        s_d     = s_q;
        s_d.div = fin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign div_o = s_q.div;

    // R3: the output pulse never lasts more than one cycle
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        div_o |=> !div_o);
    // R4: a period cannot complete without an event
    a_r4_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> evt_i);
endmodule

// File: tb/tb_dmp_divider.sv
module tb_dmp_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_i = 1'b0, load_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [5:0]  a_i = '0;
    logic [12:0] b_i = '0;
    logic        div_o, cfg_err_o;

    always #10 clk = ~clk;

    dmp_divider dut (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .load_i(load_i),
        .mode_i(mode_i), .a_i(a_i), .b_i(b_i), .div_o(div_o), .cfg_err_o(cfg_err_o));

    int errors = 0, checks = 0;
    // reference model state
    int m_cnt = 0;
    logic [1:0] am = 2'd0, pm = 2'd0;
    int aa = 0, ab = 3, pa = 0, pb = 3;
    bit pv = 0;
    bit exp_div = 0, exp_err = 0;

    function automatic int n_of(input logic [1:0] m, input int a, input int b);
        return (8 << m) * b + a;
    endfunction

    function automatic bit is_legal(input int a, input int b);
        return (b >= 3) && (b >= a);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit e, input bit l,
                        input logic [1:0] md, input int av, input int bv);
        @(negedge clk);
        evt_i = e; load_i = l; mode_i = md; a_i = 6'(av); b_i = 13'(bv);
        @(posedge clk);
        #1;
        exp_div = 0;
        if (l) begin
            if (is_legal(av, bv)) begin
                pm = md; pa = av; pb = bv; pv = 1; exp_err = 0;
            end else begin
                exp_err = 1;
            end
        end
        if (e) begin
            m_cnt++;
            if (m_cnt == n_of(am, aa, ab)) begin
                exp_div = 1; m_cnt = 0;
                if (pv) begin am = pm; aa = pa; ab = pb; pv = 0; end
            end
        end
        check(tag, "div_o", int'(div_o), int'(exp_div));
        check(tag, "cfg_err_o", int'(cfg_err_o), int'(exp_err));
    endtask

    task automatic run_events(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1, 0, 2'(i), i, i);
    endtask

    // finish the running period so that pending settings are active
    task automatic finish_period(input string tag);
        int left;
        left = n_of(am, aa, ab) - m_cnt;
        run_events(tag, left);
    endtask

    task automatic load(input string tag, input logic [1:0] md, input int av, input int bv);
        step(tag, 0, 1, md, av, bv);
    endtask

    // count events until a pulse; compare with expected period length
    task automatic measure(input string tag, input int exp_n);
        int n;
        n = 0;
        do begin
            step(tag, 1, 0, 2'd3, 63, 1);
            n++;
        end while (!div_o && n < 6000);
        check(tag, "period length", n, exp_n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4021));
        repeat (3) @(posedge clk);
        #1;
        check("R1", "div_o in reset", int'(div_o), 0);
        check("R1", "cfg_err_o in reset", int'(cfg_err_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1: default N=24
        measure("R1", 24);

        // R4: idle gaps do not count
        for (int i = 0; i < 24; i++) begin
            step("R4", 1, 0, 0, 0, 3);
            repeat (i % 4) step("R4", 0, 0, 2'd3, 9, 9);
        end

        // R2: every prescaler code
        for (int m = 0; m < 4; m++) begin
            load("R2", 2'(m), 2, 4);
            finish_period("R2");
            measure("R2", n_of(2'(m), 2, 4));
        end

        // R5: B below 3 rejected, old setting kept
        load("R7", 2'd0, 1, 5);
        finish_period("R7");
        load("R5", 2'd1, 0, 2);
        finish_period("R5");
        measure("R5", 41);
        // R6: B less than A rejected
        load("R6", 2'd0, 10, 9);
        finish_period("R6");
        measure("R6", 41);
        // R7: legal load clears the flag
        load("R7", 2'd0, 9, 9);
        check("R7", "cfg_err_o after legal", int'(cfg_err_o), 0);
        finish_period("R7");
        measure("R7", 81);

        // R8: load mid-period keeps the running length
        run_events("R8", 10);
        load("R8", 2'd1, 0, 3);
        measure("R8", 81 - 10);
        measure("R8", 48);

        // R9: load on the completing event
        run_events("R9", 47);
        step("R9", 1, 1, 2'd0, 3, 5);
        check("R9", "pulse on collision", int'(div_o), 1);
        measure("R9", 43);
        // rejected load on the completing event keeps the ratio
        run_events("R9", 42);
        step("R9", 1, 1, 2'd0, 3, 1);
        check("R9", "pulse on rejected collision", int'(div_o), 1);
        measure("R9", 43);

        // R10: bus values without load have no effect
        for (int i = 0; i < 100; i++)
            step("R10", i % 2 == 0, 0, 2'($urandom), int'($urandom % 64), int'($urandom % 64));
        finish_period("R10");
        measure("R10", 43);

        // R11: boundaries
        load("R11", 2'd2, 0, 3);
        finish_period("R11");
        measure("R11", 96);
        load("R11", 2'd3, 63, 63);
        finish_period("R11");
        measure("R11", 64 * 63 + 63);
        load("R11", 2'd0, 3, 3);
        finish_period("R11");
        measure("R11", 27);

        // R2: constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit e, l;
            int av, bv;
            e  = ($urandom % 4) != 0;
            l  = ($urandom % 60) == 0;
            av = int'($urandom % 20);
            bv = int'($urandom % 24);
            step("R2", e, l, 2'($urandom % 2), av, bv);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule